// File: doc/BRIEF.md
# SPI timing parameter calculator

This block turns a set of SPI timing wishes into the register values a serial master needs. Given the frequency of the clock that feeds the master, the fastest SCK the attached device tolerates, and three delays in nanoseconds, it works out two results. The delays are the chip-select lead before the first SCK edge, the gap between back-to-back frames, and the chip-select lag after the last SCK edge. The first result is a power-of-two prescale exponent. The second is a 32-bit control word holding the SCK divider and the three delays, each counted in prescaled clock cycles.

A single-cycle start pulse samples the inputs. A sequential unit then runs several steps through one shared restoring divider and a leading-zero counter. It finds the base clock period, the cycle counts that are needed, the smallest exponent that lets the largest count fit in 8 bits, the scaled period, and the ceiling-rounded delays. When the results are valid it raises done for one cycle. The outputs hold until the next result.

Top module: `spi_timing_calc`

## Requirements
- R1: After reset, ctrl_word, prescale, err and done are all 0.
- R2: Let base = 1e9 / root_hz and div = root_hz / sck_max_hz (integer quotients), and m = max(max(lead_ns, gap_ns, lag_ns) / base, div). The raw exponent is 0 when m has 24 or more leading zeros in 32 bits (m ≤ 255), and 24 minus that leading-zero count otherwise.
- R3: A raw exponent above 7 is reported as prescale = 7 with err = 1. Otherwise prescale equals the raw exponent and err = 0.
- R4: The SCK divider field, ctrl_word[7:0], is (div >> prescale) − 1. When div >> prescale is 0 the field is 0, not negative.
- R5: With the scaled period P = 1e9 / (root_hz >> prescale), each delay becomes ceil(delay / P). An offset is then subtracted, but only when the rounded value is at least that offset: 2 for gap_ns and 1 for lead_ns and lag_ns. Field positions: gap in ctrl_word[15:8], lead in ctrl_word[23:16], lag in ctrl_word[31:24].
- R6: Any field value above 255 after its offset is reported as 255.
- R7: Inputs are captured on the start cycle. Changes to them afterwards, and further start pulses while a computation is running, do not alter the result and produce no extra done.
- R8: done is high for exactly one cycle per accepted start. ctrl_word, prescale and err change only in that cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that samples the inputs and starts a computation |
| root_hz | input | 32 | Frequency of the master's root clock in Hz |
| sck_max_hz | input | 32 | Highest SCK frequency allowed by the device in Hz |
| lead_ns | input | 32 | Chip-select to first SCK edge delay in ns |
| gap_ns | input | 32 | Gap between consecutive frames in ns |
| lag_ns | input | 32 | Last SCK edge to chip-select release delay in ns |
| ctrl_word | output | 32 | Packed fields: lag, lead, gap, SCK divider (MSB to LSB) |
| prescale | output | 3 | Prescale exponent; the clock is divided by 2 to this power |
| err | output | 1 | Required exponent exceeded 7 |
| done | output | 1 | One-cycle pulse marking valid outputs |

## Verification
The assertions assume that root_hz is nonzero and at most 1e9, so that the base period and the scaled clock are never zero. They also assume that sck_max_hz is nonzero, so that every division inside the block has a nonzero divisor. The remainder-bound check is therefore guarded on a nonzero divisor. The directed stimulus keeps every root clock between 66 MHz and 256 MHz and every SCK limit at 100 Hz or above, which satisfies these assumptions. It spends its variety on divisor, delay and exponent boundaries instead.

// File: rtl/spi_timing_pkg.sv
package spi_timing_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BASE,
    ST_CYC,
    ST_SCK,
    ST_EXP,
    ST_PER,
    ST_LEAD,
    ST_GAP,
    ST_LAG,
    ST_PACK
  } calc_state_t;

  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned FLD_DIV    = 0;
  localparam int unsigned FLD_GAP    = 1;
  localparam int unsigned FLD_LEAD   = 2;
  localparam int unsigned FLD_LAG    = 3;

  function automatic int unsigned field_offset(input int unsigned idx);
    return (idx == FLD_GAP) ? 2 : 1;
  endfunction

endpackage

// File: rtl/spi_udiv.sv
module spi_udiv #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, d_r;
  logic [CW-1:0] cnt_r;
  logic          busy_r, done_r;
  logic [W:0]    part, trial;

  assign part  = {r_r, q_r[W-1]};
  assign trial = part - {1'b0, d_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (go && !busy_r) begin
        q_r    <= dividend;
        r_r    <= '0;
        d_r    <= divisor;
        cnt_r  <= CW'(W);
        busy_r <= 1'b1;
      end else if (busy_r) begin
        if (!trial[W]) begin
          r_r <= trial[W-1:0];
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= part[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quot = q_r;
  assign rem  = r_r;

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    (done_r && (d_r != '0)) |-> (r_r < d_r)); // R5

  AST_DIV_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy_r); // R7

endmodule

// File: rtl/spi_lzc.sv
module spi_lzc #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] zeros
);
  always_comb begin
    logic seen;
    seen  = 1'b0;
    zeros = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!seen) begin
        if (val[i]) seen = 1'b1;
        else        zeros = zeros + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_field_fit.sv
module spi_field_fit #(
  parameter int unsigned VW   = 33,
  parameter int unsigned FW   = 8,
  parameter int unsigned OFFS = 1
) (
  input  logic [VW-1:0] val,
  output logic [FW-1:0] fld
);
  localparam logic [VW-1:0] OFFS_V = VW'(OFFS);
  localparam logic [VW-1:0] MAX_V  = VW'((1 << FW) - 1);

  logic [VW-1:0] adj;

  always_comb begin
    adj = (val >= OFFS_V) ? (val - OFFS_V) : val;
    fld = (adj > MAX_V) ? MAX_V[FW-1:0] : adj[FW-1:0];
  end
endmodule

// File: rtl/spi_timing_calc.sv
module spi_timing_calc
  import spi_timing_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned FW       = 8,
  parameter int unsigned EW       = 3,
  parameter int unsigned NS_PER_S = 1_000_000_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [DW-1:0]            root_hz,
  input  logic [DW-1:0]            sck_max_hz,
  input  logic [DW-1:0]            lead_ns,
  input  logic [DW-1:0]            gap_ns,
  input  logic [DW-1:0]            lag_ns,
  output logic [NUM_FIELDS*FW-1:0] ctrl_word,
  output logic [EW-1:0]            prescale,
  output logic                     err,
  output logic                     done
);
  localparam int unsigned   LZW       = $clog2(DW + 1);
  localparam int unsigned   EXP_MAX   = (1 << EW) - 1;
  localparam int unsigned   FIT_ZEROS = DW - FW;
  localparam logic [DW-1:0] NS_V      = DW'(NS_PER_S);
  localparam logic [DW-1:0] FIT_LIMIT = DW'(1 << FW);

  calc_state_t st;
  logic             go_r;
  logic [DW-1:0]    root_r, sck_r, lead_r, gap_r, lag_r, maxd_r;
  logic [DW-1:0]    base_r, cyc_r, div_r, per_r;
  logic [EW-1:0]    exp_r;
  logic             ovf_r;
  logic [DW:0]      ceil_r [NUM_FIELDS];

  logic [NUM_FIELDS*FW-1:0] ctrl_q;
  logic [EW-1:0]            prescale_q;
  logic                     err_q, done_q;

  // largest requested delay at the start cycle
  logic [DW-1:0] max_lead_gap, maxd_w;
  assign max_lead_gap = (lead_ns > gap_ns) ? lead_ns : gap_ns;
  assign maxd_w       = (max_lead_gap > lag_ns) ? max_lead_gap : lag_ns;

  // shared divider
  logic [DW-1:0] dv_n, dv_d, dv_q, dv_r;
  logic          dv_busy, dv_done;

  always_comb begin
    dv_n = '0;
    dv_d = '0;
    case (st)
      ST_BASE: begin dv_n = NS_V;   dv_d = root_r;          end
      ST_CYC:  begin dv_n = maxd_r; dv_d = base_r;          end
      ST_SCK:  begin dv_n = root_r; dv_d = sck_r;           end
      ST_PER:  begin dv_n = NS_V;   dv_d = root_r >> exp_r; end
      ST_LEAD: begin dv_n = lead_r; dv_d = per_r;           end
      ST_GAP:  begin dv_n = gap_r;  dv_d = per_r;           end
      ST_LAG:  begin dv_n = lag_r;  dv_d = per_r;           end
      default: begin dv_n = '0;     dv_d = '0;              end
    endcase
  end

  spi_udiv #(.W(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (go_r),
    .dividend (dv_n),
    .divisor  (dv_d),
    .busy     (dv_busy),
    .done     (dv_done),
    .quot     (dv_q),
    .rem      (dv_r)
  );

  // ceiling of the current quotient
  logic [DW:0] ceil_w;
  assign ceil_w = {1'b0, dv_q} + (DW + 1)'(|dv_r);

  // exponent selection
  logic [DW-1:0]  m_w;
  logic [LZW-1:0] lz_w;
  logic [LZW-1:0] exp_raw_w;
  logic [EW-1:0]  exp_sat_w;
  logic           exp_ovf_w;

  assign m_w = (cyc_r > div_r) ? cyc_r : div_r;

  spi_lzc #(.W(DW), .CW(LZW)) u_lzc (
    .val   (m_w),
    .zeros (lz_w)
  );

  always_comb begin
    exp_raw_w = (lz_w >= LZW'(FIT_ZEROS)) ? '0 : (LZW'(FIT_ZEROS) - lz_w);
    exp_ovf_w = (exp_raw_w > LZW'(EXP_MAX));
    exp_sat_w = exp_ovf_w ? EW'(EXP_MAX) : exp_raw_w[EW-1:0];
  end

  // field fitting: offset then saturation, one per field
  logic [FW-1:0]            fld_w [NUM_FIELDS];
  logic [NUM_FIELDS*FW-1:0] packed_w;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fit
    spi_field_fit #(
      .VW   (DW + 1),
      .FW   (FW),
      .OFFS (field_offset(gi))
    ) u_fit (
      .val (ceil_r[gi]),
      .fld (fld_w[gi])
    );
    assign packed_w[gi*FW +: FW] = fld_w[gi];
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      go_r       <= 1'b0;
      root_r     <= '0;
      sck_r      <= '0;
      lead_r     <= '0;
      gap_r      <= '0;
      lag_r      <= '0;
      maxd_r     <= '0;
      base_r     <= '0;
      cyc_r      <= '0;
      div_r      <= '0;
      per_r      <= '0;
      exp_r      <= '0;
      ovf_r      <= 1'b0;
      for (int i = 0; i < NUM_FIELDS; i++) ceil_r[i] <= '0;
      ctrl_q     <= '0;
      prescale_q <= '0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      go_r   <= 1'b0;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            root_r <= root_hz;
            sck_r  <= sck_max_hz;
            lead_r <= lead_ns;
            gap_r  <= gap_ns;
            lag_r  <= lag_ns;
            maxd_r <= maxd_w;
            st     <= ST_BASE;
            go_r   <= 1'b1;
          end
        end
        ST_BASE: begin
          if (dv_done) begin
            base_r <= dv_q;
            st     <= ST_CYC;
            go_r   <= 1'b1;
          end
        end
        ST_CYC: begin
          if (dv_done) begin
            cyc_r <= dv_q;
            st    <= ST_SCK;
            go_r  <= 1'b1;
          end
        end
        ST_SCK: begin
          if (dv_done) begin
            div_r <= dv_q;
            st    <= ST_EXP;
          end
        end
        ST_EXP: begin
          exp_r <= exp_sat_w;
          ovf_r <= exp_ovf_w;
          st    <= ST_PER;
          go_r  <= 1'b1;
        end
        ST_PER: begin
          if (dv_done) begin
            per_r           <= dv_q;
            ceil_r[FLD_DIV] <= {1'b0, div_r >> exp_r};
            st              <= ST_LEAD;
            go_r            <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (dv_done) begin
            ceil_r[FLD_LEAD] <= ceil_w;
            st               <= ST_GAP;
            go_r             <= 1'b1;
          end
        end
        ST_GAP: begin
          if (dv_done) begin
            ceil_r[FLD_GAP] <= ceil_w;
            st              <= ST_LAG;
            go_r            <= 1'b1;
          end
        end
        ST_LAG: begin
          if (dv_done) begin
            ceil_r[FLD_LAG] <= ceil_w;
            st              <= ST_PACK;
          end
        end
        ST_PACK: begin
          ctrl_q     <= packed_w;
          prescale_q <= exp_r;
          err_q      <= ovf_r;
          done_q     <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_word = ctrl_q;
  assign prescale  = prescale_q;
  assign err       = err_q;
  assign done      = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(ctrl_q) && $stable(prescale_q) && $stable(err_q))); // R8

  AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> (prescale_q == EW'(EXP_MAX))); // R3

  AST_EXP_ZERO_FIT: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_EXP) && (m_w < FIT_LIMIT)) |=> (exp_r == '0)); // R2

  AST_DIV_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !dv_busy); // R7

endmodule

// File: tb/test_spi_timing_calc.sv
`timescale 1ns/1ps
module test_spi_timing_calc;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] root_hz, sck_max_hz, lead_ns, gap_ns, lag_ns;
  logic [31:0] ctrl_word;
  logic [2:0]  prescale;
  logic        err;
  logic        done;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_timing_calc i_spi_timing_calc (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .root_hz    (root_hz),
    .sck_max_hz (sck_max_hz),
    .lead_ns    (lead_ns),
    .gap_ns     (gap_ns),
    .lag_ns     (lag_ns),
    .ctrl_word  (ctrl_word),
    .prescale   (prescale),
    .err        (err),
    .done       (done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] r, input logic [31:0] s,
                        input logic [31:0] l, input logic [31:0] g,
                        input logic [31:0] t);
    @(negedge clk);
    root_hz = r; sck_max_hz = s; lead_ns = l; gap_ns = g; lag_ns = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
    chk(req, "done seen", {31'd0, ok}, 32'd1);
  endtask

  task automatic expect_result(input string req, input logic [31:0] w,
                               input logic [2:0] p, input logic e);
    logic [31:0] w_seen;
    chk(req, "ctrl_word", ctrl_word, w);
    chk(req, "prescale", {29'd0, prescale}, {29'd0, p});
    chk(req, "err", {31'd0, err}, {31'd0, e});
    w_seen = ctrl_word;
    @(negedge clk);
    chk("R8", "done one cycle", {31'd0, done}, 32'd0);
    chk("R8", "ctrl_word held", ctrl_word, w_seen);
  endtask

  task automatic run_case(input string req, input logic [31:0] r, input logic [31:0] s,
                          input logic [31:0] l, input logic [31:0] g, input logic [31:0] t,
                          input logic [31:0] w, input logic [2:0] p, input logic e);
    bit ok;
    launch(r, s, l, g, t);
    wait_done(req, ok);
    if (ok) expect_result(req, w, p, e);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0;
    root_hz = '0; sck_max_hz = '0; lead_ns = '0; gap_ns = '0; lag_ns = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset ctrl_word", ctrl_word, 32'd0);
    chk("R1", "reset prescale", {29'd0, prescale}, 32'd0);
    chk("R1", "reset err", {31'd0, err}, 32'd0);
    chk("R1", "reset done", {31'd0, done}, 32'd0);
  endtask

  // slow device: 66 MHz root, exponent 5, scaled period 484 ns
  task automatic t_slow_device;
    run_case("R2 R5", 32'd66_000_000, 32'd166_666, 32'd100_000, 32'd52_000, 32'd20_000,
             32'h29CE6A0B, 3'd5, 1'b0);
  endtask

  // fast device: exponent 0, zero gap stays 0
  task automatic t_fast_device;
    run_case("R4 R5", 32'd66_000_000, 32'd12_000_000, 32'd40, 32'd0, 32'd40,
             32'h02020004, 3'd0, 1'b0);
  endtask

  // largest count 255: exponent 0; gap of one cycle is below offset 2 and stays 1
  task automatic t_count_255;
    run_case("R2 R5", 32'd255_000_000, 32'd1_000_000, 32'd3, 32'd3, 32'd4,
             32'h010001FE, 3'd0, 1'b0);
  endtask

  // largest count 256: exponent 1
  task automatic t_count_256;
    run_case("R2 R4", 32'd256_000_000, 32'd1_000_000, 32'd0, 32'd14, 32'd8,
             32'h0100007F, 3'd1, 1'b0);
  endtask

  // exponent exactly 7 without error; shifted divisor 0 gives SCK field 0
  task automatic t_exp_seven;
    run_case("R3 R4", 32'd100_000_000, 32'd1_000_000, 32'd300_000, 32'd2_560, 32'd2_561,
             32'h02EA0000, 3'd7, 1'b0);
  endtask

  // exponent overflow and field saturation
  task automatic t_saturate;
    run_case("R3 R6", 32'd100_000_000, 32'd1_000_000, 32'd2_000_000_000, 32'd0, 32'd0,
             32'h00FF0000, 3'd7, 1'b1);
    run_case("R6", 32'd100_000_000, 32'd100, 32'd0, 32'd0, 32'd0,
             32'h000000FF, 3'd7, 1'b1);
  endtask

  // inputs changed and start re-pulsed while busy: no effect
  task automatic t_busy_ignore;
    bit ok;
    bit extra;
    launch(32'd66_000_000, 32'd166_666, 32'd100_000, 32'd52_000, 32'd20_000);
    repeat (5) @(negedge clk);
    root_hz = 32'd66_000_000; sck_max_hz = 32'd12_000_000;
    lead_ns = 32'd40; gap_ns = 32'd0; lag_ns = 32'd40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R7", ok);
    if (ok) expect_result("R7", 32'h29CE6A0B, 3'd5, 1'b0);
    extra = 1'b0;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    chk("R7", "no extra done", {31'd0, extra}, 32'd0);
    chk("R7", "result kept", ctrl_word, 32'h29CE6A0B);
  endtask

  initial begin
    #(5.0 * 150_000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_slow_device();
    t_fast_device();
    t_count_255();
    t_count_256();
    t_exp_seven();
    t_saturate();
    t_busy_ignore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule